// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block is the digital controller that sits in front of an external 10-bit successive-approximation converter core. It steers a 3-bit analog multiplexer select across eight inputs. For each conversion it waits a programmable settling interval and then pulses a start strobe to the core. When the core reports done, the block captures the 10-bit code into a result register reserved for that channel.

Software configures the block through a small word-wide register port. It chooses a mode, a first channel and a settling length, then writes a command. Single mode converts the chosen channel once. Scan mode walks upward from the chosen channel to channel 7, one full conversion per channel. A busy indication covers the whole sequence, and a one-cycle completion pulse marks its normal end. Clearing the enable bit abandons a sequence at once.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy, core_start and seq_done are low, mux_sel is 0, and every readable register returns 0.
- R2: Register map (reg_addr): 0 = control (bit 0 enable, bit 1 scan when 1 / single when 0, bits 4:2 first channel); 1 = settle length in bits 7:0; 2 = command, where a write with bit 0 set requests a start; 3 = status (bit 0 busy, bits 15:8 per-channel done flags, bit n+8 for channel n); 8+n = result of channel n in bits 9:0 with upper bits zero. Reads are combinational.
- R3: A start request is accepted only while idle and enabled, and busy rises in the following cycle. A request while busy or while disabled is ignored. Busy never rises without an accepted request.
- R4: Each channel is held on mux_sel for settle+1 cycles before core_start pulses high for one cycle. mux_sel then stays on that channel until its result is stored or the sequence ends.
- R5: When core_done is high during a conversion, the 10-bit code and that channel's done flag are written at that clock edge. core_done while idle or settling changes nothing.
- R6: Single mode converts only the first channel. Busy then falls, and seq_done is high for exactly the first idle cycle.
- R7: Scan mode converts channels in ascending order from the first channel through channel 7, with a full settle before each. A first channel of 7 converts only channel 7.
- R8: An accepted start clears all done flags. Result registers of channels not converted in the new sequence keep their earlier values.
- R9: Clearing enable while busy returns the block to idle in the next cycle, with no seq_done pulse and no further core_start. Results and flags already stored stay as they are.
- R10: Writes to the settle length register while busy are discarded.
- R11: Codes across the full range 000h to 3FFh are stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address, used for writes and reads |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| mux_sel | output | 3 | Analog multiplexer channel select |
| core_start | output | 1 | One-cycle conversion start to the converter core |
| core_done | input | 1 | Converter core reports a finished conversion |
| core_data | input | 10 | Converter core result code |
| busy | output | 1 | A sequence is in progress |
| seq_done | output | 1 | One-cycle pulse when a sequence completes normally |

## Verification
The assertions check these rules on every cycle:
- core_start only pulses after the settle interval and only while busy.
- mux_sel does not move during a channel's conversion, and it advances by exactly one after each store in a scan.
- Each store lands in the result and flag of the channel that was selected.
- Busy cannot rise without an accepted command.
- An abort leaves idle state with no completion pulse.

Only the bench's scenarios can show the following:
- Which channels a whole sequence covers.
- That results of untouched channels survive.
- That a start issued mid-scan or a settle write while busy has no effect.
- That a done pulse arriving after an abort, or while idle, is dropped.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Control-region register offsets (low address bits, region bit clear)
    localparam int REG_CTRL  = 0;
    localparam int REG_TIME  = 1;
    localparam int REG_CMD   = 2;
    localparam int REG_STAT  = 3;

    // Bit positions inside the control and status words
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_SCAN_BIT = 1;
    localparam int CTRL_CH_LSB   = 2;
    localparam int STAT_FLAG_LSB = 8;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_CONV   = 2'd2
    } phase_t;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int CH_W   = 3,
    parameter int RES_W  = 10,
    parameter int DATA_W = 16,
    parameter int SET_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    input  logic                        busy,
    input  logic [NCH-1:0]              flags,
    input  logic [NCH-1:0][RES_W-1:0]   results,
    output logic                        enable,
    output logic                        scan,
    output logic [CH_W-1:0]             start_ch,
    output logic [SET_W-1:0]            settle,
    output logic                        start_cmd
);

    localparam int LOW_W = ADDR_W - 1;

    typedef struct packed {
        logic              en;
        logic              scan;
        logic [CH_W-1:0]   stch;
        logic [SET_W-1:0]  settle;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic             region;
    logic [LOW_W-1:0] sub;
    logic             unused_wdata;

    assign region       = reg_addr[ADDR_W-1];
    assign sub          = reg_addr[LOW_W-1:0];
    assign unused_wdata = ^reg_wdata[DATA_W-1:SET_W];

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr && !region) begin
            if (sub == LOW_W'(REG_CTRL)) begin
                cfg_d.en   = reg_wdata[CTRL_EN_BIT];
                cfg_d.scan = reg_wdata[CTRL_SCAN_BIT];
                cfg_d.stch = reg_wdata[CTRL_CH_LSB +: CH_W];
            end
            if (sub == LOW_W'(REG_TIME) && !busy) begin
                cfg_d.settle = reg_wdata[SET_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign start_cmd = reg_wr && !region && (sub == LOW_W'(REG_CMD)) && reg_wdata[0];
    assign enable    = cfg_q.en;
    assign scan      = cfg_q.scan;
    assign start_ch  = cfg_q.stch;
    assign settle    = cfg_q.settle;

    always_comb begin
        reg_rdata = '0;
        if (region) begin
            reg_rdata[RES_W-1:0] = results[sub[CH_W-1:0]];
        end else begin
            case (sub)
                LOW_W'(REG_CTRL): begin
                    reg_rdata[CTRL_EN_BIT]           = cfg_q.en;
                    reg_rdata[CTRL_SCAN_BIT]         = cfg_q.scan;
                    reg_rdata[CTRL_CH_LSB +: CH_W]   = cfg_q.stch;
                end
                LOW_W'(REG_TIME): reg_rdata[SET_W-1:0] = cfg_q.settle;
                LOW_W'(REG_STAT): begin
                    reg_rdata[0]                     = busy;
                    reg_rdata[STAT_FLAG_LSB +: NCH]  = flags;
                end
                default: reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int CH_W  = 3,
    parameter int SET_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              scan,
    input  logic [CH_W-1:0]   start_ch,
    input  logic [SET_W-1:0]  settle,
    input  logic              start_cmd,
    input  logic              core_done,
    output logic [CH_W-1:0]   mux_sel,
    output logic              core_start,
    output logic              busy,
    output logic              seq_done,
    output logic              store,
    output logic [CH_W-1:0]   store_ch,
    output logic              clr_flags
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

    typedef struct packed {
        phase_t            phase;
        logic [CH_W-1:0]   ch;
        logic              mode;
        logic [SET_W-1:0]  cnt;
        logic              start;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        seq_d.done  = 1'b0;
        store       = 1'b0;
        clr_flags   = 1'b0;
        case (seq_q.phase)
            PH_IDLE: begin
                if (start_cmd && enable) begin
                    seq_d.phase = PH_SETTLE;
                    seq_d.ch    = start_ch;
                    seq_d.mode  = scan;
                    seq_d.cnt   = settle;
                    clr_flags   = 1'b1;
                end
            end
            PH_SETTLE: begin
                if (!enable) begin
                    seq_d.phase = PH_IDLE;
                end else if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_CONV;
                    seq_d.start = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_CONV: begin
                if (!enable) begin
                    seq_d.phase = PH_IDLE;
                end else if (core_done) begin
                    store = 1'b1;
                    if (seq_q.mode && seq_q.ch != LAST_CH) begin
                        seq_d.ch    = seq_q.ch + 1'b1;
                        seq_d.cnt   = settle;
                        seq_d.phase = PH_SETTLE;
                    end else begin
                        seq_d.phase = PH_IDLE;
                        seq_d.done  = 1'b1;
                    end
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{phase: PH_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign mux_sel    = seq_q.ch;
    assign store_ch   = seq_q.ch;
    assign core_start = seq_q.start;
    assign seq_done   = seq_q.done;
    assign busy       = (seq_q.phase != PH_IDLE);

endmodule

// File: rtl/adc_seq_bank.sv
module adc_seq_bank #(
    parameter int NCH   = 8,
    parameter int CH_W  = 3,
    parameter int RES_W = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       store,
    input  logic [CH_W-1:0]            store_ch,
    input  logic [RES_W-1:0]           store_data,
    input  logic                       clr_flags,
    output logic [NCH-1:0][RES_W-1:0]  results,
    output logic [NCH-1:0]             flags
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        typedef struct packed {
            logic              flag;
            logic [RES_W-1:0]  val;
        } slot_t;

        slot_t slot_d, slot_q;
        logic  hit;

        assign hit = store && (store_ch == CH_W'(i));

        always_comb begin
            slot_d = slot_q;
            if (clr_flags) slot_d.flag = 1'b0;
            if (hit) begin
                slot_d.flag = 1'b1;
                slot_d.val  = store_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign results[i] = slot_q.val;
        assign flags[i]   = slot_q.flag;
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter  int NCH    = 8,
    parameter  int RES_W  = 10,
    parameter  int DATA_W = 16,
    parameter  int SET_W  = 8,
    localparam int CH_W   = $clog2(NCH),
    localparam int ADDR_W = CH_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [CH_W-1:0]    mux_sel,
    output logic               core_start,
    input  logic               core_done,
    input  logic [RES_W-1:0]   core_data,
    output logic               busy,
    output logic               seq_done
);

    logic                       enable_w;
    logic                       scan_w;
    logic [CH_W-1:0]            start_ch_w;
    logic [SET_W-1:0]           settle_w;
    logic                       start_cmd_w;
    logic                       store_w;
    logic [CH_W-1:0]            store_ch_w;
    logic                       clr_flags_w;
    logic [NCH-1:0]             flags_w;
    logic [NCH-1:0][RES_W-1:0]  results_w;

    adc_seq_regs #(
        .NCH(NCH), .CH_W(CH_W), .RES_W(RES_W),
        .DATA_W(DATA_W), .SET_W(SET_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .flags     (flags_w),
        .results   (results_w),
        .enable    (enable_w),
        .scan      (scan_w),
        .start_ch  (start_ch_w),
        .settle    (settle_w),
        .start_cmd (start_cmd_w)
    );

    adc_seq_fsm #(
        .NCH(NCH), .CH_W(CH_W), .SET_W(SET_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable_w),
        .scan       (scan_w),
        .start_ch   (start_ch_w),
        .settle     (settle_w),
        .start_cmd  (start_cmd_w),
        .core_done  (core_done),
        .mux_sel    (mux_sel),
        .core_start (core_start),
        .busy       (busy),
        .seq_done   (seq_done),
        .store      (store_w),
        .store_ch   (store_ch_w),
        .clr_flags  (clr_flags_w)
    );

    adc_seq_bank #(
        .NCH(NCH), .CH_W(CH_W), .RES_W(RES_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .store      (store_w),
        .store_ch   (store_ch_w),
        .store_data (core_data),
        .clr_flags  (clr_flags_w),
        .results    (results_w),
        .flags      (flags_w)
    );

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
    parameter int NCH   = 8,
    parameter int CH_W  = 3,
    parameter int RES_W = 10,
    parameter int SET_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       busy,
    input logic                       core_start,
    input logic                       seq_done,
    input logic [CH_W-1:0]            mux_sel,
    input logic                       enable,
    input logic [SET_W-1:0]           settle_len,
    input logic                       start_cmd,
    input logic                       store,
    input logic [CH_W-1:0]            store_ch,
    input logic [RES_W-1:0]           core_data,
    input logic [NCH-1:0]             flags,
    input logic [NCH-1:0][RES_W-1:0]  results
);

    localparam int HELD_W = SET_W + 1;
    localparam logic [HELD_W-1:0] HELD_MAX = '1;

    logic [HELD_W-1:0] held_q;
    logic [CH_W-1:0]   prev_sel_q;

    // Counts busy cycles in which mux_sel repeated its previous value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q     <= '0;
            prev_sel_q <= '0;
        end else begin
            prev_sel_q <= mux_sel;
            if (!busy || mux_sel != prev_sel_q) held_q <= '0;
            else if (held_q != HELD_MAX)        held_q <= held_q + 1'b1;
        end
    end

    assert_settle_before_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> (busy && held_q >= {1'b0, settle_len}));

    assert_sel_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !store) |=> (!busy || mux_sel == $past(mux_sel)));

    assert_store_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> (flags[$past(store_ch)] && results[$past(store_ch)] == $past(core_data)));

    assert_busy_needs_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start_cmd && enable)) |=> !busy);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (!busy && $past(busy)));

    assert_scan_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> (!busy || mux_sel == $past(store_ch) + CH_W'(1)));

    assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !enable) |=> (!busy && !seq_done));

endmodule

bind adc_seq_ctrl adc_seq_checker #(
    .NCH(NCH), .CH_W(CH_W), .RES_W(RES_W), .SET_W(SET_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .core_start (core_start),
    .seq_done   (seq_done),
    .mux_sel    (mux_sel),
    .enable     (enable_w),
    .settle_len (settle_w),
    .start_cmd  (start_cmd_w),
    .store      (store_w),
    .store_ch   (store_ch_w),
    .core_data  (core_data),
    .flags      (flags_w),
    .results    (results_w)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;

    localparam int NCH = 8;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [2:0]  mux_sel;
    logic        core_start;
    logic        core_done = 1'b0;
    logic [9:0]  core_data = '0;
    logic        busy;
    logic        seq_done;

    always #2 clk = ~clk;

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mux_sel(mux_sel),
        .core_start(core_start), .core_done(core_done), .core_data(core_data),
        .busy(busy), .seq_done(seq_done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_phase, m_cnt, m_ch, m_mode, m_en, m_scanreg, m_stch, m_settle, m_flags;
    int m_res[NCH];
    bit m_start, m_done;

    always @(posedge clk) begin : model
        int ns, nd, ph0;
        bit sc;
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_ch = 0; m_mode = 0; m_en = 0;
            m_scanreg = 0; m_stch = 0; m_settle = 0; m_flags = 0;
            foreach (m_res[k]) m_res[k] = 0;
            m_start = 0; m_done = 0;
        end else begin
            ns = 0; nd = 0; ph0 = m_phase;
            sc = reg_wr && reg_addr == 4'd2 && reg_wdata[0];
            case (m_phase)
                0: if (sc && m_en != 0) begin
                       m_phase = 1; m_ch = m_stch; m_mode = m_scanreg;
                       m_cnt = m_settle; m_flags = 0;
                   end
                1: if (m_en == 0) m_phase = 0;
                   else if (m_cnt == 0) begin m_phase = 2; ns = 1; end
                   else m_cnt--;
                default: if (m_en == 0) m_phase = 0;
                   else if (core_done) begin
                       m_res[m_ch] = core_data;
                       m_flags |= (1 << m_ch);
                       if (m_mode != 0 && m_ch != NCH - 1) begin
                           m_ch++; m_cnt = m_settle; m_phase = 1;
                       end else begin
                           m_phase = 0; nd = 1;
                       end
                   end
            endcase
            if (reg_wr && reg_addr == 4'd1 && ph0 == 0) m_settle = reg_wdata[7:0];
            if (reg_wr && reg_addr == 4'd0) begin
                m_en = reg_wdata[0]; m_scanreg = reg_wdata[1]; m_stch = reg_wdata[4:2];
            end
            m_start = ns[0]; m_done = nd[0];
        end
    end

    // Every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy == (m_phase != 0), "R3 busy", busy, m_phase != 0);
            chk(mux_sel == m_ch[2:0], "R4 mux_sel", mux_sel, m_ch);
            chk(core_start == m_start, "R4 core_start", core_start, m_start);
            chk(seq_done == m_done, "R6 seq_done", seq_done, m_done);
        end
    end

    // ---------------- converter core emulation ----------------
    int  pend = 0;
    int  pat = 0;
    bit  inject = 0;
    int  dq[$];

    always @(negedge clk) begin
        core_done = 1'b0;
        if (inject) begin
            core_done = 1'b1; core_data = 10'h2AA; inject = 0;
        end
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                core_done = 1'b1;
                if (dq.size() > 0) core_data = 10'(dq.pop_front());
                else begin core_data = 10'((pat * 123 + 45) & 'h3FF); pat++; end
            end
        end
        if (core_start) pend = LAT;
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 16'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string tag);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 4'(a);
        #1;
        chk(reg_rdata == 16'(exp), tag, reg_rdata, exp);
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 2000; g++) begin
            @(negedge clk);
            if (m_phase == 0) break;
        end
        @(negedge clk);
    endtask

    int pre5;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(3, 0, "R1 status after reset");
        rd_chk(0, 0, "R1 control after reset");
        rd_chk(8, 0, "R1 result0 after reset");
        rd_chk(15, 0, "R1 result7 after reset");

        // R6 single conversion of channel 2, settle 3
        wr(1, 3);
        wr(0, 1 | (2 << 2));
        dq.push_back('h155);
        wr(2, 1);
        wait_idle();
        rd_chk(10, 'h155, "R6 single result ch2");
        rd_chk(3, 1 << 10, "R2 status flags single");
        rd_chk(11, 0, "R6 neighbour untouched");

        // R7 / R8 scan from channel 5
        wr(0, 1 | 2 | (5 << 2));
        wr(2, 1);
        wait_idle();
        for (int c = 5; c < 8; c++) rd_chk(8 + c, m_res[c], "R7 scan result");
        rd_chk(3, 'hE0 << 8, "R8 flags cleared and set");
        rd_chk(10, 'h155, "R8 old result kept");

        // R3 / R10 full scan with settle 0, start and settle write while busy
        wr(1, 0);
        wr(0, 1 | 2);
        wr(2, 1);
        repeat (5) @(negedge clk);
        wr(2, 1);
        wr(1, 9);
        wait_idle();
        rd_chk(1, 0, "R10 settle write while busy dropped");
        rd_chk(3, 'hFF << 8, "R7 all flags after full scan");
        for (int c = 0; c < 8; c++) rd_chk(8 + c, m_res[c], "R5 full scan result");

        // R11 extreme codes
        wr(0, 1 | 2 | (6 << 2));
        dq.push_back('h3FF);
        dq.push_back('h000);
        wr(2, 1);
        wait_idle();
        rd_chk(14, 'h3FF, "R11 max code");
        rd_chk(15, 'h000, "R11 min code");

        // R7 scan from the last channel
        wr(0, 1 | 2 | (7 << 2));
        wr(2, 1);
        wait_idle();
        rd_chk(3, 'h80 << 8, "R7 last-channel scan");

        // R3 start while disabled
        wr(0, 2 | (3 << 2));
        wr(2, 1);
        rd_chk(3, 'h80 << 8, "R3 start while disabled");

        // R5 done while idle
        pre5 = m_res[5];
        @(negedge clk); inject = 1;
        repeat (3) @(negedge clk);
        rd_chk(13, pre5, "R5 done while idle ignored");

        // R9 abort during scan
        wr(1, 2);
        wr(0, 1 | 2 | (1 << 2));
        wr(2, 1);
        pre5 = m_res[5];
        for (int g = 0; g < 500; g++) begin
            @(negedge clk);
            if (m_flags & 2) break;
        end
        wr(0, 0);
        repeat (20) @(negedge clk);
        rd_chk(3, 2 << 8, "R9 abort status");
        rd_chk(13, pre5, "R9 result kept after abort");
        rd_chk(9, m_res[1], "R9 stored result kept");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule